// File: doc/BRIEF.md
# Serial Control Register Port

This block is a synchronous serial slave that gives a host controller access to a small bank of 8-bit control registers. The host frames each transfer by pulling the active-low chip select down, sets the direction on a read/write line and exchanges sixteen bits over one serial data line: an 8-bit address word followed by an 8-bit data word, each most significant bit first. The data line is bidirectional at the pad; here it is split into an input, an output and an output enable, and the pad ring merges them.

The port runs directly on the serial clock and uses only its rising edge, both to sample and to change what it drives. Only the upper six bits of the address word select a register, so the registers sit at multiples of four. Index 0 holds a fixed identification byte (part code in the high nibble, version code in the low nibble). Index 1 is a read-only status byte that reflects the transmit and receive enables and the receiver's frame-search state. The remaining indices are writable control registers with defined reset values. Writes are accepted only while both transmit and receive are disabled, which keeps the control settings steady while the datapath is running.

Top module: `cfgport_top`

## Requirements
- R1: While `cs_n` is low, each rising `sclk` edge takes one bit from `sd_in`, most significant bit first: edges 1 to 8 of a transfer carry the address word and edges 9 to 16 the data word. `rw` is sampled at edge 8 (1 = read, 0 = write).
- R2: The register index is address bits 7:2. Address bits 1:0 have no effect, so addresses 08h, 09h, 0Ah and 0Bh all reach index 2.
- R3: On a read, `sd_oe` rises and `sd_out` shows data bit 7 after edge 8. Each later edge moves to the next lower bit, and `sd_oe` falls after edge 16. At every other time `sd_oe` is low, and `sd_out` is 0 whenever `sd_oe` is low.
- R4: Index 0 reads as {PART_CODE, VERSION} (35h by default), and writes to it have no effect.
- R5: Index 1 reads as bit 0 = `rx_en`, bit 1 = `tx_en`, bit 4 = `rx_en` AND `sfd_search`, with all other bits 0. It is read-only.
- R6: Indices 2 to NREG-1 (2 to 7 by default) are writable, and a read returns the value last written.
- R7: A write takes effect at edge 16 only if `tx_en` and `rx_en` are both low at that edge. Otherwise the register keeps its value.
- R8: A rising `sclk` edge with `rst_n` low (synchronous reset) loads each writable index k with {k[3:0], ~k[3:0]} (for example 2Dh at index 2 and 78h at index 7) and clears the transfer state.
- R9: If `cs_n` goes high before edge 16, the transfer is abandoned. No register changes, `sd_oe` is low after the next edge, and the next transfer starts again with an address bit.
- R10: Indices NREG and above are unmapped. They read as 00h, and writes to them change nothing.
- R11: After edge 16, further edges with `cs_n` still low are ignored until `cs_n` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low transfer frame |
| rw | input | 1 | Direction, 1 = read, sampled with the last address bit |
| sd_in | input | 1 | Serial data from the host |
| sd_out | output | 1 | Serial read data to the host |
| sd_oe | output | 1 | Drive enable for the data pad |
| tx_en | input | 1 | Transmit power enable |
| rx_en | input | 1 | Receive power enable |
| sfd_search | input | 1 | Receiver is searching for a frame delimiter |

## Verification
The bench goes after the handover between the address and data phases. A design that loaded read data one edge late would shift every bit down by one position, and one that enabled the driver during the address phase would fight the host on the shared line. It aborts transfers part-way through the data word and sends extra bits after the sixteenth edge. A port that did not restart its count on chip select would then misalign every later transfer, and one that kept counting would write on the wrong edge. It writes with each enable raised alone and writes through aliased, read-only and unmapped addresses, so a missing enable gate, a full 8-bit address decode or an unguarded index shows up as a wrong value on read-back.

// File: rtl/cfgport_pkg.sv
// Shared constants and the reset-value rule for the serial register port.
package cfgport_pkg;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 8;
    localparam int XFER_BITS = ADDR_W + DATA_W;
    localparam int CNT_W     = $clog2(XFER_BITS + 1);
    localparam int IDX_W     = ADDR_W - 2;
    localparam int FIRST_RW  = 2;

    // Reset value of writable register k: index in the high nibble, its complement low.
    function automatic logic [DATA_W-1:0] reset_value(input int k);
        logic [3:0] n;
        n = 4'(k);
        return {n, ~n};
    endfunction
endpackage

// File: rtl/cfgport_shift.sv
// Bit-level engine of the serial port: counts the 16 edges of a transfer,
// collects the address and data words and serialises read data.
// Assumes cs_n, rw and sd_in are stable around each rising sclk edge.
module cfgport_shift
    import cfgport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rw,
    input  logic              sd_in,
    input  logic [DATA_W-1:0] rd_byte,
    output logic [ADDR_W-1:0] addr_word,
    output logic              addr_done,
    output logic [ADDR_W-1:0] addr_q,
    output logic              rd_q,
    output logic [DATA_W-1:0] data_word,
    output logic              data_done,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic              sd_out,
    output logic              sd_oe
);
    localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(XFER_BITS - 1);
    localparam logic [CNT_W-1:0] DONE      = CNT_W'(XFER_BITS);

    logic [ADDR_W-1:0] in_sh;
    logic [DATA_W-1:0] out_sh;
    logic              drive_q;

    // Words as they stand at the edge that completes them.
    assign addr_word = {in_sh[ADDR_W-2:0], sd_in};
    assign data_word = {in_sh[DATA_W-2:0], sd_in};
    assign addr_done = !cs_n && (bit_cnt == LAST_ADDR);
    assign data_done = !cs_n && (bit_cnt == LAST_DATA);

    // Edge counter, input shifter and read serialiser.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            in_sh   <= '0;
            out_sh  <= '0;
            drive_q <= 1'b0;
            rd_q    <= 1'b0;
            addr_q  <= '0;
        end else if (cs_n) begin
            bit_cnt <= '0;
            drive_q <= 1'b0;
        end else if (bit_cnt != DONE) begin
            bit_cnt <= bit_cnt + 1'b1;
            in_sh   <= addr_word;
            if (bit_cnt == LAST_ADDR) begin
                addr_q <= addr_word;
                rd_q   <= rw;
                if (rw) begin
                    drive_q <= 1'b1;
                    out_sh  <= rd_byte;
                end
            end else if (bit_cnt == LAST_DATA) begin
                drive_q <= 1'b0;
            end else begin
                out_sh <= {out_sh[DATA_W-2:0], 1'b0};
            end
        end
    end

    // The pad sees a quiet low level whenever the port is not driving.
    assign sd_oe  = drive_q;
    assign sd_out = drive_q & out_sh[DATA_W-1];
endmodule

// File: rtl/cfgport_regs.sv
// Register bank: fixed ID at index 0, status at index 1, writable
// registers with reset values above, zero for unmapped indices.
// Assumes wr_en is already qualified by the transfer and enable rules.
module cfgport_regs
    import cfgport_pkg::*;
#(
    parameter int NREG = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic [IDX_W-1:0]             rd_idx,
    input  logic [DATA_W-1:0]            id_byte,
    input  logic [DATA_W-1:0]            status_byte,
    output logic [DATA_W-1:0]            rd_data,
    output logic [(NREG-FIRST_RW)*DATA_W-1:0] image
);
    localparam int NRW = NREG - FIRST_RW;

    // One storage byte per writable index.
    for (genvar k = FIRST_RW; k < NREG; k++) begin : g_rw
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(k);
        logic [DATA_W-1:0] q;
        // Holds the register; reset to its default, updated on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)                         q <= reset_value(k);
            else if (wr_en && wr_idx == MY_IDX) q <= wr_data;
        end
        assign image[(k-FIRST_RW)*DATA_W +: DATA_W] = q;
    end

    // Read selection across fixed, writable and unmapped indices.
    always_comb begin
        if (rd_idx == IDX_W'(0))                rd_data = id_byte;
        else if (rd_idx == IDX_W'(1))           rd_data = status_byte;
        else if (int'(rd_idx) < NREG)           rd_data = image[(int'(rd_idx)-FIRST_RW)*DATA_W +: DATA_W];
        else                                    rd_data = '0;
    end

    if (NRW < 1) begin : g_bad
        initial $error("NREG must exceed the read-only indices");
    end
endmodule

// File: rtl/cfgport_top.sv
// Serial slave port onto a bank of 8-bit control registers.
// Runs on the serial clock; sclk must be low-skew and free of glitches.
module cfgport_top
    import cfgport_pkg::*;
#(
    parameter int         NREG      = 8,
    parameter logic [3:0] PART_CODE = 4'h3,
    parameter logic [3:0] VERSION   = 4'h5
) (
    input  logic sclk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic rw,
    input  logic sd_in,
    output logic sd_out,
    output logic sd_oe,
    input  logic tx_en,
    input  logic rx_en,
    input  logic sfd_search
);
    logic [ADDR_W-1:0] addr_word, addr_q;
    logic              addr_done, data_done, rd_q;
    logic [DATA_W-1:0] data_word, rd_data, status_byte;
    logic [CNT_W-1:0]  bit_cnt;
    logic              wr_en;
    logic [(NREG-FIRST_RW)*DATA_W-1:0] rf_image;

    // Live status byte presented at index 1.
    assign status_byte = {3'b000, rx_en & sfd_search, 2'b00, tx_en, rx_en};

    // A write lands only when both datapath enables are off.
    assign wr_en = data_done && !rd_q && !tx_en && !rx_en;

    cfgport_shift u_shift (
        .clk       (sclk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .rw        (rw),
        .sd_in     (sd_in),
        .rd_byte   (rd_data),
        .addr_word (addr_word),
        .addr_done (addr_done),
        .addr_q    (addr_q),
        .rd_q      (rd_q),
        .data_word (data_word),
        .data_done (data_done),
        .bit_cnt   (bit_cnt),
        .sd_out    (sd_out),
        .sd_oe     (sd_oe)
    );

    cfgport_regs #(.NREG(NREG)) u_regs (
        .clk         (sclk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_idx      (addr_q[ADDR_W-1:2]),
        .wr_data     (data_word),
        .rd_idx      (addr_word[ADDR_W-1:2]),
        .id_byte     ({PART_CODE, VERSION}),
        .status_byte (status_byte),
        .rd_data     (rd_data),
        .image       (rf_image)
    );

    logic unused_ok;
    assign unused_ok = addr_done;
endmodule

// File: rtl/cfgport_chk.sv
// Protocol and storage checks for cfgport_top, attached by bind.
module cfgport_chk
    import cfgport_pkg::*;
#(
    parameter int NREG = 8
) (
    input logic                               sclk,
    input logic                               rst_n,
    input logic                               cs_n,
    input logic                               rw,
    input logic                               sd_oe,
    input logic                               tx_en,
    input logic                               rx_en,
    input logic [CNT_W-1:0]                   bit_cnt,
    input logic [(NREG-FIRST_RW)*DATA_W-1:0]  rf_image
);
    // R9: a high chip select leaves the pad undriven after the edge.
    p_idle_quiet_r9: assert property (@(posedge sclk) disable iff (!rst_n)
        cs_n |=> !sd_oe);

    // R3: a read enables the driver right after the last address edge.
    p_oe_start_r3: assert property (@(posedge sclk) disable iff (!rst_n)
        (!cs_n && rw && bit_cnt == CNT_W'(ADDR_W - 1)) |=> sd_oe);

    // R3: the driver is on only inside the data phase.
    p_oe_window_r3: assert property (@(posedge sclk) disable iff (!rst_n)
        sd_oe |-> (bit_cnt >= CNT_W'(ADDR_W) && bit_cnt <= CNT_W'(XFER_BITS - 1)));

    // R7: no register moves while either enable is high.
    p_hold_busy_r7: assert property (@(posedge sclk) disable iff (!rst_n)
        (tx_en || rx_en) |=> $stable(rf_image));

    // R9: nothing is written while no transfer is framed.
    p_hold_idle_r9: assert property (@(posedge sclk) disable iff (!rst_n)
        cs_n |=> $stable(rf_image));

    // R11: a finished transfer stays finished until chip select rises.
    p_done_hold_r11: assert property (@(posedge sclk) disable iff (!rst_n)
        (!cs_n && bit_cnt == CNT_W'(XFER_BITS)) |=> bit_cnt == CNT_W'(XFER_BITS));

    // R8: leaving reset starts from an idle, undriven state.
    p_reset_idle_r8: assert property (@(posedge sclk) disable iff (!rst_n)
        $rose(rst_n) |-> (!sd_oe && bit_cnt == '0));
endmodule

bind cfgport_top cfgport_chk #(.NREG(NREG)) u_chk (
    .sclk     (sclk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .rw       (rw),
    .sd_oe    (sd_oe),
    .tx_en    (tx_en),
    .rx_en    (rx_en),
    .bit_cnt  (bit_cnt),
    .rf_image (rf_image)
);

// File: tb/tb_cfgport_top.sv
// Bench for cfgport_top: behavioural reference model compared every clock,
// plus directed read-back checks on each requirement.
module tb_cfgport_top;
    logic sclk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, rw = 1'b0, sd_in = 1'b0;
    logic tx_en = 1'b0, rx_en = 1'b0, sfd_search = 1'b0;
    logic sd_out, sd_oe;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 sclk = ~sclk;

    cfgport_top dut (
        .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .sd_in(sd_in),
        .sd_out(sd_out), .sd_oe(sd_oe), .tx_en(tx_en), .rx_en(rx_en),
        .sfd_search(sfd_search)
    );

    // Reference model state.
    logic [7:0] mem [0:63];
    int         m_pos = 0;
    logic [7:0] m_addr = 0, m_data = 0, m_byte = 0;
    bit         m_rd = 0, m_oe = 0;
    int         m_bit = 7;

    function automatic logic [7:0] model_read(input logic [7:0] a);
        int idx = int'(a[7:2]);
        if (idx == 0) return 8'h35;
        if (idx == 1) return {3'b000, rx_en & sfd_search, 2'b00, tx_en, rx_en};
        if (idx < 8)  return mem[idx];
        return 8'h00;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Model update on every rising edge, from the inputs the DUT sees.
    always @(posedge sclk) begin
        if (!rst_n) begin
            m_pos = 0; m_oe = 0;
            for (int k = 0; k < 64; k++) mem[k] = {k[3:0], ~k[3:0]};
        end else if (cs_n) begin
            m_pos = 0; m_oe = 0;
        end else if (m_pos < 16) begin
            if (m_pos < 8) m_addr = {m_addr[6:0], sd_in};
            else           m_data = {m_data[6:0], sd_in};
            if (m_pos == 7) begin
                m_rd = rw;
                if (rw) begin m_oe = 1; m_byte = model_read(m_addr); m_bit = 7; end
            end else if (m_pos == 15) begin
                m_oe = 0;
                if (!m_rd && !tx_en && !rx_en && m_addr[7:2] >= 2 && m_addr[7:2] < 8)
                    mem[m_addr[7:2]] = m_data;
            end else if (m_pos > 7) begin
                m_bit = m_bit - 1;
            end
            m_pos++;
        end
    end

    // Per-clock comparison of the pad outputs, away from the active edge (R3).
    always @(negedge sclk) begin
        if (rst_n && !finished) begin
            check(sd_oe === m_oe, "R3 oe", sd_oe, m_oe);
            check(sd_out === (m_oe ? m_byte[m_bit] : 1'b0), "R3 out", sd_out,
                  m_oe ? m_byte[m_bit] : 1'b0);
        end
    end

    // One framed transfer of nbits edges; returns the bits seen on sd_out.
    task automatic xfer(input bit rd, input logic [7:0] a, input logic [7:0] wd,
                        input int nbits, output logic [7:0] rdv);
        rdv = 8'h00;
        for (int i = 0; i < nbits; i++) begin
            @(negedge sclk);
            if (i >= 8 && i < 16) rdv[15-i] = sd_out;
            cs_n  = 1'b0;
            rw    = rd;
            sd_in = (i < 8) ? a[7-i] : (i < 16) ? wd[15-i] : 1'b1;
        end
        @(negedge sclk);
        cs_n = 1'b1; sd_in = 1'b0; rw = 1'b0;
        @(negedge sclk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        logic [7:0] dummy;
        xfer(1'b0, a, d, 16, dummy);
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
        logic [7:0] v;
        xfer(1'b1, a, 8'h00, 16, v);
        check(v === exp, req, v, exp);
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge sclk);
        rst_n = 1'b1;
        @(negedge sclk);
        check(sd_oe === 1'b0, "R8 idle after reset", sd_oe, 0);

        // R8: reset values of every writable index.
        for (int k = 2; k < 8; k++) rd_chk(8'(k*4), {k[3:0], ~k[3:0]}, "R8 default");

        // R4: identification byte, and a write to it is ignored.
        rd_chk(8'h00, 8'h35, "R4 id");
        wr(8'h00, 8'hFF);
        rd_chk(8'h00, 8'h35, "R4 id write ignored");

        // R5: status under several enable patterns, read-only.
        tx_en = 1; rx_en = 1; sfd_search = 1;
        rd_chk(8'h04, 8'h13, "R5 status all on");
        sfd_search = 0;
        rd_chk(8'h04, 8'h03, "R5 status no search");
        tx_en = 0; rx_en = 0; sfd_search = 1;
        rd_chk(8'h04, 8'h00, "R5 status rx off");
        wr(8'h04, 8'hFF);
        rd_chk(8'h04, 8'h00, "R5 status write ignored");
        sfd_search = 0;

        // R1, R6: write then read back several patterns MSB first.
        wr(8'h08, 8'hA5);  rd_chk(8'h08, 8'hA5, "R6 idx2");
        wr(8'h1C, 8'h81);  rd_chk(8'h1C, 8'h81, "R1 idx7 msb/lsb");
        wr(8'h0C, 8'h00);  rd_chk(8'h0C, 8'h00, "R6 idx3 zero");

        // R2: low address bits are ignored.
        wr(8'h13, 8'h5A);
        rd_chk(8'h10, 8'h5A, "R2 alias write");
        rd_chk(8'h12, 8'h5A, "R2 alias read");

        // R7: each enable alone blocks a write.
        tx_en = 1; wr(8'h14, 8'hEE); tx_en = 0;
        rd_chk(8'h14, 8'h5A, "R7 tx_en blocks");
        rx_en = 1; wr(8'h14, 8'hEE); rx_en = 0;
        rd_chk(8'h14, 8'h5A, "R7 rx_en blocks");

        // R10: unmapped reads zero, writes leave mapped registers alone.
        rd_chk(8'h20, 8'h00, "R10 unmapped read");
        wr(8'h20, 8'h77);
        wr(8'hFC, 8'h77);
        rd_chk(8'h20, 8'h00, "R10 unmapped write");
        rd_chk(8'h08, 8'hA5, "R10 no alias into idx2");

        // R9: abort inside the data word, then a clean transfer.
        xfer(1'b0, 8'h08, 8'h3C, 12, v);
        rd_chk(8'h08, 8'hA5, "R9 abort no write");
        xfer(1'b1, 8'h1C, 8'h00, 10, v);
        rd_chk(8'h1C, 8'h81, "R9 resync after read abort");

        // R11: extra edges after the sixteenth change nothing.
        xfer(1'b0, 8'h18, 8'hC3, 20, v);
        rd_chk(8'h18, 8'hC3, "R11 extra bits ignored");

        // R8: reset restores defaults after writes.
        @(negedge sclk); rst_n = 0; @(negedge sclk); rst_n = 1; @(negedge sclk);
        rd_chk(8'h08, 8'h2D, "R8 reset restores idx2");
        rd_chk(8'h1C, 8'h78, "R8 reset restores idx7");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge sclk);
        if (!finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule